// File: doc/BRIEF.md
# Write-Protection Command Sequencer

This block sits in front of the byte-load path of a page-programmed non-volatile memory. It decides whether each write strobe from the host may reach the page buffer. Two things gate a write. The first is a set of electrical-style inhibits: a write-enable pulse that is too short, output enable held low, chip enable high, and a low-supply sense input. The second is a protection flag. While that flag is clear, every qualified write is passed on. While it is set, a write gets through only after a fixed three-write command sequence has opened a load window. That window closes when the page buffer signals the end of its load, and protection then re-arms by itself.

A write that the flag refuses is dropped without further effect. The block only raises a one-cycle illegal flag for it. It does not start any write-status or polling behaviour. Running the command sequence while the flag is clear sets the flag. If the first write inside an opened window carries a disarm pair, the flag is cleared. The flag is held in a register whose reset value is taken from a preset input, which stands in for a non-volatile cell.

Top module: `wp_sequencer`

## Requirements
- R1: While rst_n is low, wr_accept and wr_illegal are 0 and prot_on takes the value of prot_preset. That value holds after reset is released.
- R2: A write is qualified when we_n has been sampled low on MIN_LOW consecutive rising edges (default 3) with ce_n low, oe_n high and supply_low low throughout. With prot_on at 0, wr_accept is 1 for exactly one cycle after the MIN_LOW-th such edge. In that cycle acc_addr and acc_data hold the addr and din sampled at that edge.
- R3: A we_n low pulse shorter than MIN_LOW edges produces no wr_accept and no wr_illegal. A longer pulse produces exactly one event.
- R4: No event is produced by a write while oe_n is low, while ce_n is high, or while supply_low is high. Any of these conditions restarts the low-time count.
- R5: The command sequence consists of three qualified writes: (0x05555, 0xAA), then (0x02AAA, 0x55), then (0x05555, 0xA0). Completing it sets prot_on to 1 in the cycle after the third write. If prot_on was 0, the three writes are accepted as normal writes.
- R6: While prot_on is 1 and no window is open, a write that does not match the expected command step gives wr_illegal for one cycle and no wr_accept.
- R7: While prot_on is 1, writes that match the expected command step give neither wr_accept nor wr_illegal.
- R8: A mismatching write at any step returns the sequence to its first step. A full three-write sequence is then needed again.
- R9: After the sequence completes, every qualified write is accepted until page_end is seen high. After that, writes are refused again while prot_on is 1.
- R10: If the first write after a completed sequence is (0x05555, 0x20), prot_on is cleared in the next cycle, that write is not accepted, and the window closes.
- R11: wr_accept and wr_illegal are never 1 in the same cycle. prot_on changes only through R5 or R10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prot_preset | input | 1 | Value loaded into the protection flag during reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low; low inhibits writes |
| we_n | input | 1 | Write strobe, active low |
| supply_low | input | 1 | High while the supply is below the write threshold |
| addr | input | AW | Write address |
| din | input | DW | Write data |
| page_end | input | 1 | Pulse from the page buffer marking the end of a load |
| wr_accept | output | 1 | One-cycle strobe: write forwarded to the page buffer |
| wr_illegal | output | 1 | One-cycle flag: write refused by protection |
| acc_addr | output | AW | Address of the accepted write |
| acc_data | output | DW | Data of the accepted write |
| prot_on | output | 1 | Protection flag |

## Verification
The write strobe is driven with pulses of one less than, exactly, and well above the minimum low time. This separates glitch rejection from single-event generation. The same write is repeated under each inhibit, one at a time, which shows that every inhibit blocks on its own. Command writes are issued in order, with a wrong value in the middle, and with the last step alone. These patterns distinguish silent consumption, illegal flagging and sequence restart. The sequence is also run with the flag clear, in front of a disarm pair, and in front of an ordinary data load closed by page_end. These runs tell arming, disarming and automatic re-locking apart.

// File: rtl/wps_pkg.sv
package wps_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE       = 3'd0,
    SQ_ONE        = 3'd1,
    SQ_TWO        = 3'd2,
    SQ_OPEN_FIRST = 3'd3,
    SQ_OPEN       = 3'd4
  } seq_state_e;

  typedef struct packed {
    logic accept;
    logic illegal;
  } verdict_t;

  // refusal rule shared by the three command steps
  function automatic verdict_t step_verdict(input logic prot, input logic hit);
    verdict_t v;
    v.accept  = !prot;
    v.illegal = prot && !hit;
    return v;
  endfunction

  function automatic logic is_window(input seq_state_e s);
    return (s == SQ_OPEN_FIRST) || (s == SQ_OPEN);
  endfunction

endpackage

// File: rtl/wps_strobe_filter.sv
module wps_strobe_filter #(
  parameter int MIN_LOW = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic we_n,
  input  logic ce_n,
  input  logic oe_n,
  input  logic supply_low,
  output logic fire
);
  localparam int CW = $clog2(MIN_LOW + 1);
  localparam logic [CW-1:0] LAST = CW'(MIN_LOW - 1);
  localparam logic [CW-1:0] SAT  = CW'(MIN_LOW);

  logic          qual;
  logic [CW-1:0] low_cnt;

  assign qual = !we_n && !ce_n && oe_n && !supply_low;
  assign fire = qual && (low_cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)             low_cnt <= '0;
    else if (!qual)         low_cnt <= '0;
    else if (low_cnt != SAT) low_cnt <= low_cnt + 1'b1;
  end
endmodule

// File: rtl/wps_cmd_fsm.sv
module wps_cmd_fsm
  import wps_pkg::*;
#(
  parameter int             AW      = 17,
  parameter int             DW      = 8,
  parameter logic [AW-1:0]  STEP0_A = 17'h05555,
  parameter logic [DW-1:0]  STEP0_D = 8'hAA,
  parameter logic [AW-1:0]  STEP1_A = 17'h02AAA,
  parameter logic [DW-1:0]  STEP1_D = 8'h55,
  parameter logic [AW-1:0]  STEP2_A = 17'h05555,
  parameter logic [DW-1:0]  STEP2_D = 8'hA0,
  parameter logic [AW-1:0]  DISARM_A = 17'h05555,
  parameter logic [DW-1:0]  DISARM_D = 8'h20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          prot_preset,
  input  logic          fire,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  input  logic          page_end,
  output verdict_t      verdict,
  output logic          prot_on,
  output logic          seq_done,
  output logic          disarm,
  output logic          window_open
);
  seq_state_e st, st_n;
  logic       prot_n;
  logic       hit0, hit1, hit2, hitd;

  assign hit0 = (addr == STEP0_A) && (din == STEP0_D);
  assign hit1 = (addr == STEP1_A) && (din == STEP1_D);
  assign hit2 = (addr == STEP2_A) && (din == STEP2_D);
  assign hitd = (addr == DISARM_A) && (din == DISARM_D);
  assign window_open = is_window(st);

  always_comb begin
    st_n     = st;
    prot_n   = prot_on;
    verdict  = '0;
    seq_done = 1'b0;
    disarm   = 1'b0;
    if (fire) begin
      case (st)
        SQ_IDLE: begin
          verdict = step_verdict(prot_on, hit0);
          st_n    = hit0 ? SQ_ONE : SQ_IDLE;
        end
        SQ_ONE: begin
          verdict = step_verdict(prot_on, hit1);
          st_n    = hit1 ? SQ_TWO : SQ_IDLE;
        end
        SQ_TWO: begin
          verdict = step_verdict(prot_on, hit2);
          if (hit2) begin
            st_n     = SQ_OPEN_FIRST;
            prot_n   = 1'b1;
            seq_done = 1'b1;
          end else begin
            st_n = SQ_IDLE;
          end
        end
        SQ_OPEN_FIRST: begin
          if (hitd) begin
            prot_n = 1'b0;
            disarm = 1'b1;
            st_n   = SQ_IDLE;
          end else begin
            verdict.accept = 1'b1;
            st_n           = SQ_OPEN;
          end
        end
        SQ_OPEN: verdict.accept = 1'b1;
        default: st_n = SQ_IDLE;
      endcase
    end
    if (page_end && window_open) st_n = SQ_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= SQ_IDLE;
      prot_on <= prot_preset;
    end else begin
      st      <= st_n;
      prot_on <= prot_n;
    end
  end
endmodule

// File: rtl/wp_sequencer.sv
module wp_sequencer
  import wps_pkg::*;
#(
  parameter int AW      = 17,
  parameter int DW      = 8,
  parameter int MIN_LOW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          prot_preset,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic          supply_low,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  input  logic          page_end,
  output logic          wr_accept,
  output logic          wr_illegal,
  output logic [AW-1:0] acc_addr,
  output logic [DW-1:0] acc_data,
  output logic          prot_on
);
  logic     fire;
  logic     seq_done;
  logic     disarm;
  logic     window_open;
  verdict_t verdict;

  wps_strobe_filter #(.MIN_LOW(MIN_LOW)) u_filter (
    .clk(clk), .rst_n(rst_n), .we_n(we_n), .ce_n(ce_n), .oe_n(oe_n),
    .supply_low(supply_low), .fire(fire)
  );

  wps_cmd_fsm #(.AW(AW), .DW(DW)) u_fsm (
    .clk(clk), .rst_n(rst_n), .prot_preset(prot_preset), .fire(fire),
    .addr(addr), .din(din), .page_end(page_end), .verdict(verdict),
    .prot_on(prot_on), .seq_done(seq_done), .disarm(disarm),
    .window_open(window_open)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_accept  <= 1'b0;
      wr_illegal <= 1'b0;
      acc_addr   <= '0;
      acc_data   <= '0;
    end else begin
      wr_accept  <= verdict.accept;
      wr_illegal <= verdict.illegal;
      if (verdict.accept) begin
        acc_addr <= addr;
        acc_data <= din;
      end
    end
  end
endmodule

// File: rtl/wps_checker.sv
module wps_checker #(
  parameter int MIN_LOW = 3
) (
  input logic clk,
  input logic rst_n,
  input logic we_n,
  input logic ce_n,
  input logic oe_n,
  input logic supply_low,
  input logic page_end,
  input logic wr_accept,
  input logic wr_illegal,
  input logic prot_on,
  input logic seq_done,
  input logic disarm,
  input logic window_open
);
  assert_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_accept && wr_illegal));

  assert_inhibit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_accept || wr_illegal) |-> $past(!we_n && !ce_n && oe_n && !supply_low));

  generate
    if (MIN_LOW >= 2) begin : g_width
      assert_glitch_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_accept || wr_illegal) |-> $past(!we_n, 2));
    end
  endgenerate

  assert_locked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_accept |-> ($past(!prot_on) || $past(window_open)));

  assert_arm_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prot_on) |-> $past(seq_done));

  assert_disarm_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(prot_on) |-> $past(disarm));

  assert_relock_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(page_end) |-> !window_open);
endmodule

bind wp_sequencer wps_checker #(.MIN_LOW(MIN_LOW)) u_chk (
  .clk(clk), .rst_n(rst_n), .we_n(we_n), .ce_n(ce_n), .oe_n(oe_n),
  .supply_low(supply_low), .page_end(page_end), .wr_accept(wr_accept),
  .wr_illegal(wr_illegal), .prot_on(prot_on), .seq_done(seq_done),
  .disarm(disarm), .window_open(window_open)
);

// File: tb/wp_sequencer_bench.sv
module wp_sequencer_bench;
  localparam int MINL = 3;
  localparam logic [16:0] A0 = 17'h05555, A1 = 17'h02AAA, A2 = 17'h05555, AD = 17'h05555;
  localparam logic [7:0]  D0 = 8'hAA, D1 = 8'h55, D2 = 8'hA0, DD = 8'h20;

  logic clk = 0, rst_n = 0, prot_preset = 0;
  logic ce_n = 0, oe_n = 1, we_n = 1, supply_low = 0, page_end = 0;
  logic [16:0] addr = '0;
  logic [7:0]  din = '0;
  logic wr_accept, wr_illegal, prot_on;
  logic [16:0] acc_addr;
  logic [7:0]  acc_data;

  wp_sequencer u_wp_sequencer (
    .clk(clk), .rst_n(rst_n), .prot_preset(prot_preset), .ce_n(ce_n), .oe_n(oe_n),
    .we_n(we_n), .supply_low(supply_low), .addr(addr), .din(din),
    .page_end(page_end), .wr_accept(wr_accept), .wr_illegal(wr_illegal),
    .acc_addr(acc_addr), .acc_data(acc_data), .prot_on(prot_on)
  );

  always #2 clk = ~clk;

  int checks = 0, fails = 0, cycles = 0;
  int acc_cnt = 0, ill_cnt = 0;
  logic [16:0] last_addr;
  logic [7:0]  last_data;
  string cur_req = "R1";

  // behavioural reference: low-time counter, step index, flag
  int  m_low = 0, m_step = 0;
  bit  m_prot = 0, m_acc = 0, m_ill = 0;
  logic [16:0] m_addr;
  logic [7:0]  m_data;

  always @(posedge clk) begin
    bit ok, f, match;
    if (!rst_n) begin
      m_low = 0; m_step = 0; m_prot = prot_preset; m_acc = 0; m_ill = 0;
    end else begin
      ok = !we_n && !ce_n && oe_n && !supply_low;
      f  = ok && (m_low == MINL - 1);
      m_low = ok ? ((m_low < MINL) ? m_low + 1 : m_low) : 0;
      m_acc = 0; m_ill = 0;
      if (f) begin
        if (m_step <= 2) begin
          match = (m_step == 0) ? (addr == A0 && din == D0) :
                  (m_step == 1) ? (addr == A1 && din == D1) : (addr == A2 && din == D2);
          m_acc = !m_prot;
          m_ill = m_prot && !match;
          if (!match) m_step = 0;
          else if (m_step == 2) begin m_step = 3; m_prot = 1; end
          else m_step = m_step + 1;
        end else if (m_step == 3 && addr == AD && din == DD) begin
          m_prot = 0; m_step = 0;
        end else begin
          m_acc = 1; m_step = 4;
        end
        if (m_acc) begin m_addr = addr; m_data = din; end
      end
      if (page_end && m_step >= 3) m_step = 0;
    end
  end

  always @(negedge clk) begin
    if (wr_accept) begin acc_cnt++; last_addr = acc_addr; last_data = acc_data; end
    if (wr_illegal) ill_cnt++;
    checks++;
    if (wr_accept !== m_acc || wr_illegal !== m_ill || prot_on !== m_prot ||
        (m_acc && (acc_addr !== m_addr || acc_data !== m_data))) begin
      fails++;
      $display("FAIL %s model: got acc=%b ill=%b prot=%b a=%h d=%h exp acc=%b ill=%b prot=%b a=%h d=%h",
               cur_req, wr_accept, wr_illegal, prot_on, acc_addr, acc_data,
               m_acc, m_ill, m_prot, m_addr, m_data);
    end
  end

  task automatic chk(input string req, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  task automatic wr(input logic [16:0] a, input logic [7:0] d, input int low = MINL,
                    input logic ce = 0, input logic oe = 1, input logic sup = 0);
    @(negedge clk);
    addr = a; din = d; ce_n = ce; oe_n = oe; supply_low = sup; we_n = 0;
    repeat (low) @(negedge clk);
    we_n = 1; ce_n = 0; oe_n = 1; supply_low = 0;
    repeat (2) @(negedge clk);
    #1;
  endtask

  task automatic unlock();
    wr(A0, D0); wr(A1, D1); wr(A2, D2);
  endtask

  task automatic pulse_end();
    @(negedge clk); page_end = 1;
    @(negedge clk); page_end = 0;
    #1;
  endtask

  task automatic do_reset(input logic pre);
    @(negedge clk); rst_n = 0; prot_preset = pre;
    repeat (3) @(negedge clk);
    #1;
    chk("R1", "prot_on during reset", prot_on, pre);
    chk("R1", "wr_accept during reset", wr_accept, 0);
    @(negedge clk); rst_n = 1;
    repeat (2) @(negedge clk);
    #1;
    chk("R1", "prot_on after reset", prot_on, pre);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++; fails++;
      $display("FAIL watchdog: got %0d cycles expected completion", cycles);
      summary();
    end
  end

  initial begin
    int a0, i0;
    do_reset(0);

    cur_req = "R2";
    a0 = acc_cnt;
    wr(17'h00123, 8'h3C);
    chk("R2", "accept count", acc_cnt - a0, 1);
    chk("R2", "accepted address", int'(last_addr), 32'h123);
    chk("R2", "accepted data", int'(last_data), 32'h3C);

    cur_req = "R3";
    a0 = acc_cnt;
    wr(17'h00200, 8'h11, MINL - 1);
    chk("R3", "short pulse accepts", acc_cnt - a0, 0);
    wr(17'h00201, 8'h22, MINL + 6);
    chk("R3", "long pulse accepts", acc_cnt - a0, 1);

    cur_req = "R4";
    a0 = acc_cnt;
    wr(17'h00300, 8'h33, MINL, 0, 0, 0);
    chk("R4", "oe_n low accepts", acc_cnt - a0, 0);
    wr(17'h00301, 8'h34, MINL, 1, 1, 0);
    chk("R4", "ce_n high accepts", acc_cnt - a0, 0);
    wr(17'h00302, 8'h35, MINL, 0, 1, 1);
    chk("R4", "supply_low accepts", acc_cnt - a0, 0);

    cur_req = "R5";
    a0 = acc_cnt;
    unlock();
    chk("R5", "unprotected sequence accepts", acc_cnt - a0, 3);
    chk("R5", "prot_on after sequence", prot_on, 1);

    cur_req = "R9";
    a0 = acc_cnt;
    wr(17'h00400, 8'h44); wr(17'h00401, 8'h45);
    chk("R9", "window accepts", acc_cnt - a0, 2);
    pulse_end();
    cur_req = "R6";
    a0 = acc_cnt; i0 = ill_cnt;
    wr(17'h00402, 8'h46);
    chk("R9", "accepts after page_end", acc_cnt - a0, 0);
    chk("R6", "illegal after page_end", ill_cnt - i0, 1);

    cur_req = "R7";
    a0 = acc_cnt; i0 = ill_cnt;
    wr(A0, D0); wr(A1, D1);
    chk("R7", "command steps accepts", acc_cnt - a0, 0);
    chk("R7", "command steps illegal", ill_cnt - i0, 0);

    cur_req = "R8";
    wr(17'h00500, 8'h50);
    chk("R8", "wrong third step illegal", ill_cnt - i0, 1);
    wr(A2, D2);
    chk("R8", "lone last step illegal", ill_cnt - i0, 2);
    unlock();
    wr(17'h00501, 8'h51);
    chk("R8", "accept after full restart", acc_cnt - a0, 1);
    chk("R8", "accepted data", int'(last_data), 32'h51);
    pulse_end();

    cur_req = "R10";
    a0 = acc_cnt;
    unlock();
    wr(AD, DD);
    chk("R10", "disarm write accepts", acc_cnt - a0, 0);
    chk("R10", "prot_on after disarm", prot_on, 0);
    wr(17'h00600, 8'h66);
    chk("R10", "write after disarm accepts", acc_cnt - a0, 1);

    cur_req = "R1";
    do_reset(1);
    i0 = ill_cnt;
    wr(17'h00700, 8'h77);
    chk("R1", "preset flag refuses write", ill_cnt - i0, 1);

    cur_req = "R11";
    chk("R11", "prot_on still set", prot_on, 1);
    repeat (4) @(negedge clk);
    summary();
  end
endmodule